// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command into the sequence of column addresses that a synchronous DRAM burst walks through. When a column command arrives, it captures the start column, the programmed length code and the programmed beat order. On each following clock it presents one column address, with a flag on the final beat. Fixed-length bursts stay inside the aligned block that holds the start column. The beats are ordered either by counting up with wrap-around, or by XOR of the beat index into the low address bits.

A full-page setting makes the burst run over the entire 256-column row. It wraps from the top column back to column zero and keeps going until a stop request arrives. A stop request ends any burst early. A new column command replaces whatever burst is in progress. Command decoding and the data path sit outside this block.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `col_valid` and `last_beat` are 0.
- R2: A clock edge with `start`=1 makes the next cycle present beat 0 with `col_addr` equal to the captured `start_col`. Each later edge advances the burst by exactly one beat while it is active.
- R3: `bl_code` selects the length: 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats, and any value from 4 to 7 gives a full-page burst.
- R4: With `interleave`=0 and a fixed length L, beat i has address (start with its low log2(L) bits cleared) plus ((start + i) mod L). The upper bits never change during the burst.
- R5: With `interleave`=1 and a fixed length L, beat i has the upper bits of start and low log2(L) bits equal to (start XOR i).
- R6: `last_beat` is 1 exactly on beat L-1 of a fixed-length burst. After that edge, `col_valid` is 0 unless `start` is 1.
- R7: A full-page burst ignores `interleave`. Beat i has address (start + i) mod 256, so it wraps from 255 to 0. It never raises `last_beat` and keeps running past 256 beats.
- R8: `stop`=1 at an edge without `start` ends the active burst, so `col_valid` is 0 in the next cycle. `stop` while idle has no effect.
- R9: `start` during an active burst begins a new burst from the new `start_col` and drops the old one. When `start` and `stop` are both 1, `start` wins.
- R10: `start_col`, `bl_code` and `interleave` are sampled only at a `start` edge. Changing them during a burst does not alter its addresses or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Column command: begin a burst |
| start_col | input | 8 | Start column of the burst |
| bl_code | input | 3 | Burst length code (see R3) |
| interleave | input | 1 | 0 = sequential order, 1 = XOR order |
| stop | input | 1 | Burst stop request |
| col_valid | output | 1 | A column address is presented this cycle |
| col_addr | output | 8 | Column address of the current beat |
| last_beat | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
On every cycle, the bound checker verifies several rules. The first beat must equal the captured start column. The upper address bits must hold still inside a fixed-length burst. `last_beat` may appear only with a valid beat. A burst must end after its final beat or after a stop, must continue otherwise, and must stay idle without a command. Only the bench's scenarios can confirm the exact address order and the length for each code: counting with wrap, XOR order, and the full-page wrap through 255 to 0 over more than one row. The same holds for ignoring mode inputs mid-burst and for start winning over stop, which are checked against a reference model under directed and random stimulus.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

   typedef enum logic {
      ORDER_SEQ = 1'b0,
      ORDER_XOR = 1'b1
   } beat_order_e;

endpackage

// File: rtl/colgen_len_mask.sv
module colgen_len_mask #(
   parameter int COL_W = 8,
   parameter int LOG_W = 4
) (
   input  logic [LOG_W-1:0] len_log,
   output logic [COL_W-1:0] mask
);

   // mask bit b is set when b lies inside the aligned burst block
   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      assign mask[b] = (len_log > LOG_W'(b));
   end

endmodule

// File: rtl/colgen_beat_ctrl.sv
module colgen_beat_ctrl #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             full,
   input  logic [COL_W-1:0] mask,
   output logic             active,
   output logic [COL_W-1:0] beat,
   output logic             last
);

   logic             act_q;
   logic [COL_W-1:0] beat_q;

   assign last   = act_q && !full && (beat_q == mask);
   assign active = act_q;
   assign beat   = beat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         beat_q <= '0;
      end else if (start) begin
         act_q  <= 1'b1;
         beat_q <= '0;
      end else if (act_q) begin
         if (stop || last) begin
            act_q <= 1'b0;
         end else begin
            beat_q <= beat_q + COL_W'(1);
         end
      end
   end

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
   import sdram_colgen_pkg::*;
#(
   parameter int COL_W      = 8,
   parameter bit ENABLE_XOR = 1'b1
) (
   input  logic [COL_W-1:0] base_col,
   input  logic [COL_W-1:0] beat,
   input  logic [COL_W-1:0] mask,
   input  beat_order_e      order,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] seq_low;
   assign seq_low = (base_col + beat) & mask;

   if (ENABLE_XOR) begin : g_xor
      logic [COL_W-1:0] xor_low;
      assign xor_low = (base_col ^ beat) & mask;
      always_comb begin
         if (order == ORDER_XOR) col = (base_col & ~mask) | xor_low;
         else                    col = (base_col & ~mask) | seq_low;
      end
   end else begin : g_seq_only
      logic unused_order;
      assign unused_order = order;
      assign col = (base_col & ~mask) | seq_low;
   end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
   import sdram_colgen_pkg::*;
#(
   parameter int COL_W         = 8,
   parameter int BL_CODE_W     = 3,
   parameter int MAX_FIXED_LOG = 3,
   parameter bit ENABLE_XOR    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [COL_W-1:0]     start_col,
   input  logic [BL_CODE_W-1:0] bl_code,
   input  logic                 interleave,
   input  logic                 stop,
   output logic                 col_valid,
   output logic [COL_W-1:0]     col_addr,
   output logic                 last_beat
);

   localparam int LOG_W = $clog2(COL_W + 1);

   if (MAX_FIXED_LOG >= COL_W) begin : g_bad_len
      $error("MAX_FIXED_LOG must be below COL_W");
   end
   if ((1 << BL_CODE_W) <= MAX_FIXED_LOG + 1) begin : g_bad_code
      $error("BL_CODE_W leaves no code for full page");
   end

   // decode at the command edge
   logic             dec_full;
   logic [LOG_W-1:0] dec_log;
   beat_order_e      dec_order;

   assign dec_full  = (bl_code > BL_CODE_W'(MAX_FIXED_LOG));
   assign dec_log   = dec_full ? LOG_W'(COL_W) : LOG_W'(bl_code);
   assign dec_order = (dec_full || !interleave) ? ORDER_SEQ : ORDER_XOR;

   // burst context held for the whole burst
   logic [COL_W-1:0] base_q;
   logic [LOG_W-1:0] log_q;
   logic             full_q;
   beat_order_e      order_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         log_q   <= '0;
         full_q  <= 1'b0;
         order_q <= ORDER_SEQ;
      end else if (start) begin
         base_q  <= start_col;
         log_q   <= dec_log;
         full_q  <= dec_full;
         order_q <= dec_order;
      end
   end

   logic [COL_W-1:0] mask;
   logic [COL_W-1:0] beat;
   logic             active;
   logic             last;

   colgen_len_mask #(.COL_W(COL_W), .LOG_W(LOG_W)) u_mask (
      .len_log (log_q),
      .mask    (mask)
   );

   colgen_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .stop   (stop),
      .full   (full_q),
      .mask   (mask),
      .active (active),
      .beat   (beat),
      .last   (last)
   );

   colgen_addr_map #(.COL_W(COL_W), .ENABLE_XOR(ENABLE_XOR)) u_map (
      .base_col (base_q),
      .beat     (beat),
      .mask     (mask),
      .order    (order_q),
      .col      (col_addr)
   );

   assign col_valid = active;
   assign last_beat = last;

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
   parameter int COL_W         = 8,
   parameter int BL_CODE_W     = 3,
   parameter int MAX_FIXED_LOG = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic [COL_W-1:0]     start_col,
   input logic [BL_CODE_W-1:0] bl_code,
   input logic                 stop,
   input logic                 col_valid,
   input logic [COL_W-1:0]     col_addr,
   input logic                 last_beat
);

   // independent capture of the command context
   logic [COL_W-1:0] ck_col;
   logic             ck_full;
   logic [COL_W-1:0] ck_upper_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ck_col        <= '0;
         ck_full       <= 1'b0;
         ck_upper_mask <= '0;
      end else if (start) begin
         ck_col  <= start_col;
         ck_full <= (bl_code > BL_CODE_W'(MAX_FIXED_LOG));
         ck_upper_mask <= ({COL_W{1'b1}} << bl_code);
      end
   end

   p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (col_valid && col_addr == $past(start_col)));

   p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && !ck_full) |-> ((col_addr & ck_upper_mask) == (ck_col & ck_upper_mask)));

   p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |-> col_valid);

   p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (last_beat && !start) |=> !col_valid);

   p_full_no_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && ck_full) |-> !last_beat);

   p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start) |=> !col_valid);

   p_continue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && !last_beat && !stop) |=> col_valid);

   p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!col_valid && !start) |=> !col_valid);

endmodule

bind sdram_burst_colgen colgen_checker #(
   .COL_W         (COL_W),
   .BL_CODE_W     (BL_CODE_W),
   .MAX_FIXED_LOG (MAX_FIXED_LOG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .start_col (start_col),
   .bl_code   (bl_code),
   .stop      (stop),
   .col_valid (col_valid),
   .col_addr  (col_addr),
   .last_beat (last_beat)
);

// File: tb/tb_sdram_burst_colgen.sv
`timescale 1ns/100ps
module tb_sdram_burst_colgen;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       start;
   logic [7:0] start_col;
   logic [2:0] bl_code;
   logic       interleave;
   logic       stop;
   logic       col_valid;
   logic [7:0] col_addr;
   logic       last_beat;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   sdram_burst_colgen dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
      .bl_code(bl_code), .interleave(interleave), .stop(stop),
      .col_valid(col_valid), .col_addr(col_addr), .last_beat(last_beat)
   );

   // reference model state
   bit m_act;
   int m_s, m_code, m_il, m_i;

   function automatic int exp_len(int code);
      return (code > 3) ? 0 : (1 << code);
   endfunction

   function automatic int exp_addr(int s, int code, int il, int i);
      int mask;
      if (code > 3) return (s + i) % 256;
      mask = (1 << code) - 1;
      if (il != 0) return (s & ~mask & 255) | ((s ^ i) & mask);
      return (s & ~mask & 255) | ((s + i) & mask);
   endfunction

   function automatic bit exp_last();
      return m_act && (m_code <= 3) && (m_i == exp_len(m_code) - 1);
   endfunction

   task automatic compare(input string tag);
      logic       ev, el;
      logic [7:0] ea;
      ev = m_act;
      el = exp_last();
      ea = m_act ? 8'(exp_addr(m_s, m_code, m_il, m_i)) : col_addr;
      checks++;
      if (col_valid !== ev || last_beat !== el || (ev && col_addr !== ea)) begin
         failures++;
         $display("FAIL %s: valid=%0b addr=%02h last=%0b expected valid=%0b addr=%02h last=%0b",
                  tag, col_valid, col_addr, last_beat, ev, ea, el);
      end
   endtask

   // drive at negedge, clock, update model, check at next negedge
   task automatic cyc(input bit st, input int col, input int code, input bit il,
                      input bit sp, input string tag);
      bit lst;
      start = st; start_col = 8'(col); bl_code = 3'(code); interleave = il; stop = sp;
      lst = exp_last();
      @(posedge clk);
      if (st) begin
         m_act = 1; m_i = 0; m_s = col; m_code = code; m_il = il;
      end else if (m_act) begin
         if (sp || lst) m_act = 0;
         else m_i = (m_i + 1) % 256;
      end
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int k = 0; k < n; k++) cyc(0, 8'hA5, 2, 1, 0, tag);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
   end

   initial begin
      process::self().srandom(32'h5EED_0042);
      rst_n = 0; start = 0; start_col = 0; bl_code = 0; interleave = 0; stop = 0;
      m_act = 0; m_s = 0; m_code = 0; m_il = 0; m_i = 0;
      repeat (3) @(negedge clk);
      compare("R1 in reset");
      rst_n = 1;
      idle(2, "R1 after reset");

      // R4: sequential length 4 from 0x35 -> 35 36 37 34
      cyc(1, 8'h35, 2, 0, 0, "R4 seq4");
      idle(5, "R4/R6 seq4 beats");
      // R5: interleave length 8 from 0x5B
      cyc(1, 8'h5B, 3, 1, 0, "R5 xor8");
      idle(9, "R5/R6 xor8 beats");
      // R3: length 1 and 2
      cyc(1, 8'h10, 0, 0, 0, "R3 len1");
      idle(2, "R3 len1 end");
      cyc(1, 8'hFF, 1, 0, 0, "R3 len2 wrap");
      idle(3, "R3 len2 beats");
      cyc(1, 8'h81, 1, 1, 0, "R5 xor2");
      idle(3, "R5 xor2 beats");
      // R7: full page, interleave ignored, beyond 256 beats
      cyc(1, 8'hF0, 7, 1, 0, "R7 full start");
      idle(300, "R7 full wrap");
      cyc(0, 0, 7, 1, 1, "R8 stop full");
      idle(2, "R8 after stop");
      // R8: stop while idle
      cyc(0, 0, 2, 0, 1, "R8 idle stop");
      cyc(0, 0, 2, 0, 1, "R8 idle stop");
      // R3: code 5 is full page
      cyc(1, 8'h02, 5, 0, 0, "R3 code5 full");
      idle(12, "R3 code5 beats");
      cyc(0, 0, 0, 0, 1, "R8 stop code5");
      // R8: stop mid fixed burst
      cyc(1, 8'h40, 3, 0, 0, "R8 fixed start");
      idle(2, "R8 fixed beats");
      cyc(0, 0, 3, 0, 1, "R8 stop fixed");
      idle(2, "R8 after fixed stop");
      // R9: restart mid burst, and start with stop
      cyc(1, 8'h20, 3, 0, 0, "R9 first");
      idle(3, "R9 first beats");
      cyc(1, 8'hC6, 2, 1, 0, "R9 restart");
      idle(2, "R9 new beats");
      cyc(1, 8'h07, 3, 0, 1, "R9 start beats stop");
      idle(9, "R9 after start+stop");
      // R10: mode inputs changed during burst are ignored
      cyc(1, 8'h6D, 3, 0, 0, "R10 start");
      for (int k = 0; k < 9; k++) cyc(0, k * 37, k % 8, k[0], 0, "R10 mid-burst change");
      cyc(1, 8'h33, 7, 0, 0, "R10 full start");
      for (int k = 0; k < 6; k++) cyc(0, 255 - k, 1, 1, 0, "R10 full change");
      cyc(0, 0, 0, 0, 1, "R10 stop");

      // random mix
      for (int k = 0; k < 5000; k++) begin
         bit st, sp;
         st = ($urandom_range(0, 5) == 0);
         sp = ($urandom_range(0, 19) == 0);
         cyc(st, $urandom_range(0, 255), $urandom_range(0, 7), $urandom_range(0, 1), sp,
             "R2/R9 random");
      end
      idle(3, "R2 end");

      summary();
      $finish;
   end

endmodule